// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a clocked memory slave with a small internal array. On every rising clock edge it samples two competing address strobes, a master chip select, two secondary selects, a burst-advance input and a set of write enables. From these it sorts the cycle into one of six kinds: idle, deselect, begin read, begin write, burst step or burst hold. It then performs a read or a byte-masked write at the address that the cycle selects.

The processor strobe always starts a read, but the master select gates it. The controller strobe starts a read or a write, chosen by the write enables sampled on the same edge. It is acted on only when the processor strobe is not. After a start, the burst walks a four-beat window in one of two orders. The burst-advance input decides whether each edge moves to the next beat or stays on the current one.

Read data leaves through one of two paths, picked by a static mode input. One is a two-register path that has a pipeline stage. The other is a single-register flow-through path. The output enable acts asynchronously. The data bus is split into separate in, out and drive-enable signals. A snooze input freezes the whole block and keeps the stored words.

Top module: `sbsram_core`

## Requirements
- R1: A cycle starts when the processor strobe `proc_stb_n` is low and the master select `cs_main_n` is low, provided the secondary selects are correct. Such a cycle is always a read. All write enables are ignored on that edge and nothing is written.
- R2: The controller strobe `ctrl_stb_n` starts a cycle only when the processor strobe has not started one on the same edge. The write enables on that edge decide the cycle: if any lane is enabled, it is a write of `wdata` to `addr` on that same edge; otherwise it is a read.
- R3: The secondary selects are correct when `cs_hi` is 1 and `cs_lo_n` is 0. A processor strobe with correct master select but wrong secondary selects is a deselect. A controller strobe with the master select inactive or wrong secondary selects is a deselect, and nothing is written. A processor strobe with the master select inactive is ignored, and the edge is treated as if both strobes were high.
- R4: Lane enables, with lane 0 being bits [8:0]: `wr_all_n`=0 enables every lane. Otherwise, `byte_wr_n`=0 enables each lane whose `lane_wr_n` bit is 0. Any other combination enables no lane and makes the cycle a read.
- R5: After a start, on edges where both strobes are high (or only a blocked processor strobe is low), `adv_n`=0 moves to the next beat and `adv_n`=1 stays on the current beat. Such an edge reads, or writes when any lane is enabled.
- R6: Beat n of a burst (n = 0..3) keeps the address bits above bit 1 from the start address. Its two low bits are start XOR n when `lin_order`=0, and start + n modulo 4 when `lin_order`=1.
- R7: When `flow_mode`=0, the word read on edge k appears on `rdata` with `rdata_oe`=1 after edge k+1, and not after edge k.
- R8: When `flow_mode`=1, the word read on edge k appears on `rdata` with `rdata_oe`=1 right after edge k.
- R9: `rdata_oe` is 0 whenever `out_en_n` is 1, whenever the last edge wrote any lane, and whenever the last access was not a read. `out_en_n` takes effect without waiting for a clock edge.
- R10: When `flow_mode`=0, after a deselect edge the output keeps driving the pending word for one more cycle, then turns off.
- R11: While `snooze` is 1, `rdata_oe` is 0 and every synchronous input is ignored, with no writes and no state change. On release, operation continues from the held state with the stored words intact.
- R12: While reset is asserted and after it is released, the output is not driven until a read has taken place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_mode | input | 1 | Static: 1 selects the flow-through read path, 0 selects the pipelined path |
| lin_order | input | 1 | Static: 1 selects linear beat order, 0 selects XOR beat order |
| snooze | input | 1 | Freeze: the block holds its state and keeps its data |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| cs_main_n | input | 1 | Master select, active low |
| cs_hi | input | 1 | Secondary select, active high |
| cs_lo_n | input | 1 | Secondary select, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low, enables all lanes |
| byte_wr_n | input | 1 | Enables the per-lane write inputs, active low |
| lane_wr_n | input | NBYTES | Per-lane write enables, active low |
| addr | input | ADDR_W | Start address |
| wdata | input | DATA_W | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | DATA_W | Read data |
| rdata_oe | output | 1 | Drive enable for rdata |

## Verification
The bench builds the block with 18-bit words in two 9-bit lanes and a depth of 16. A 16-entry array lets four separate burst windows and their wraps be exercised with only a few dozen writes. It also keeps the model array in the bench small enough to check every touched word. The static mode inputs are changed only between scenarios, while the block is idle. This puts both read paths and both beat orders within reach of the same build.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_BEGIN_RD,
    CYC_BEGIN_WR,
    CYC_STEP,
    CYC_HOLD
  } cyc_e;
endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
#(
  parameter int NBYTES = 2
) (
  input  logic              active_q,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              cs_main_n,
  input  logic              cs_hi,
  input  logic              cs_lo_n,
  input  logic              adv_n,
  input  logic              wr_all_n,
  input  logic              byte_wr_n,
  input  logic [NBYTES-1:0] lane_wr_n,
  output cyc_e              cyc,
  output logic [NBYTES-1:0] lane_req
);

  logic [NBYTES-1:0] mask;
  logic              proc_go;
  logic              sel_ok;

  always_comb begin
    // global write wins over the per-lane enables
    if (!wr_all_n)      mask = '1;
    else if (!byte_wr_n) mask = ~lane_wr_n;
    else                mask = '0;

    proc_go = !proc_stb_n && !cs_main_n;
    sel_ok  = cs_hi && !cs_lo_n;

    cyc = CYC_IDLE;
    if (proc_go) begin
      cyc = sel_ok ? CYC_BEGIN_RD : CYC_DESEL;
    end else if (!ctrl_stb_n) begin
      if (!cs_main_n && sel_ok) cyc = (|mask) ? CYC_BEGIN_WR : CYC_BEGIN_RD;
      else                      cyc = CYC_DESEL;
    end else if (active_q) begin
      cyc = adv_n ? CYC_HOLD : CYC_STEP;
    end

    lane_req = (cyc == CYC_BEGIN_WR || cyc == CYC_STEP || cyc == CYC_HOLD) ? mask : '0;
  end

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
  import sbsram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BURST_LEN = 4,
  localparam int BURST_W  = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  cyc_e              cyc,
  input  logic              lin_order,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] acc_addr
);

  logic [ADDR_W-1:0]  base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  logic [BURST_W-1:0] low;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    case (cyc)
      CYC_BEGIN_RD, CYC_BEGIN_WR: begin
        base_d = ext_addr;
        cnt_d  = '0;
      end
      CYC_STEP: cnt_d = cnt_q + 1'b1;
      default: ;
    endcase
    low      = lin_order ? (base_d[BURST_W-1:0] + cnt_d) : (base_d[BURST_W-1:0] ^ cnt_d);
    acc_addr = {base_d[ADDR_W-1:BURST_W], low};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_HOLD_KEEPS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cyc == CYC_HOLD) |=> $stable(cnt_q)); // R5

  AST_STEP_MOVES_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cyc == CYC_STEP) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R6

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int DATA_W   = 18,
  parameter int BYTE_W   = 9,
  parameter int DEPTH    = 64,
  localparam int NBYTES  = DATA_W / BYTE_W,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [NBYTES-1:0] lane_we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] bit_we;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign bit_we[g*BYTE_W +: BYTE_W] = {BYTE_W{lane_we[g]}};
  end

  always_ff @(posedge clk) begin
    if (|lane_we) mem[waddr] <= (mem[waddr] & ~bit_we) | (wdata & bit_we);
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
  import sbsram_pkg::*;
#(
  parameter int DATA_W    = 18,
  parameter int BYTE_W    = 9,
  parameter int DEPTH     = 64,
  parameter int BURST_LEN = 4,
  localparam int NBYTES   = DATA_W / BYTE_W,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flow_mode,
  input  logic              lin_order,
  input  logic              snooze,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              cs_main_n,
  input  logic              cs_hi,
  input  logic              cs_lo_n,
  input  logic              adv_n,
  input  logic              wr_all_n,
  input  logic              byte_wr_n,
  input  logic [NBYTES-1:0] lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  logic              en;
  cyc_e              cyc;
  logic [NBYTES-1:0] lane_req, lane_we;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] arr_q;

  logic              active_q, active_d;
  logic              rd_valid_q, rd_valid_d;
  logic [ADDR_W-1:0] rd_addr_q, rd_addr_d;
  logic              wr_q, wr_d;
  logic              pipe_valid_q, pipe_valid_d;
  logic [DATA_W-1:0] pipe_q;

  assign en      = !snooze;
  assign lane_we = en ? lane_req : '0;

  sbsram_decode #(.NBYTES(NBYTES)) u_decode (
    .active_q   (active_q),
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .cs_main_n  (cs_main_n),
    .cs_hi      (cs_hi),
    .cs_lo_n    (cs_lo_n),
    .adv_n      (adv_n),
    .wr_all_n   (wr_all_n),
    .byte_wr_n  (byte_wr_n),
    .lane_wr_n  (lane_wr_n),
    .cyc        (cyc),
    .lane_req   (lane_req)
  );

  sbsram_burst #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_burst (
    .clk       (clk),
    .rst_n     (rst_i),
    .en        (en),
    .cyc       (cyc),
    .lin_order (lin_order),
    .ext_addr  (addr),
    .acc_addr  (acc_addr)
  );

  sbsram_array #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_array (
    .clk     (clk),
    .lane_we (lane_we),
    .waddr   (acc_addr),
    .wdata   (wdata),
    .raddr   (rd_addr_q),
    .rdata   (arr_q)
  );

  // next state
  always_comb begin
    active_d = active_q;
    if (cyc == CYC_BEGIN_RD || cyc == CYC_BEGIN_WR) active_d = 1'b1;
    else if (cyc == CYC_DESEL)                      active_d = 1'b0;

    rd_valid_d   = (cyc == CYC_BEGIN_RD) ||
                   ((cyc == CYC_STEP || cyc == CYC_HOLD) && !(|lane_req));
    rd_addr_d    = rd_valid_d ? acc_addr : rd_addr_q;
    wr_d         = |lane_req;
    pipe_valid_d = rd_valid_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      active_q     <= 1'b0;
      rd_valid_q   <= 1'b0;
      rd_addr_q    <= '0;
      wr_q         <= 1'b0;
      pipe_valid_q <= 1'b0;
    end else if (en) begin
      active_q     <= active_d;
      rd_valid_q   <= rd_valid_d;
      rd_addr_q    <= rd_addr_d;
      wr_q         <= wr_d;
      pipe_valid_q <= pipe_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (en) pipe_q <= arr_q;
  end

  // output path
  always_comb begin
    rdata    = flow_mode ? arr_q : pipe_q;
    rdata_oe = !out_en_n && en && !wr_q && (flow_mode ? rd_valid_q : pipe_valid_q);
  end

  AST_SNOOZE_QUIET: assert property (@(posedge clk) disable iff (!rst_i)
    snooze |-> !rdata_oe); // R11

  AST_QUIET_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_i)
    (!snooze && $past(|lane_we)) |-> !rdata_oe); // R9

  AST_FLOW_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_i)
    (flow_mode && $past(cyc == CYC_DESEL && !snooze)) |-> !rdata_oe); // R3

endmodule

// File: tb/tb_sbsram_core.sv
module tb_sbsram_core;

  localparam int DW = 18;
  localparam int BW = 9;
  localparam int DP = 16;
  localparam int NB = DW / BW;
  localparam int AW = $clog2(DP);

  logic          clk;
  logic          rst_n;
  logic          flow_mode, lin_order, snooze;
  logic          proc_stb_n, ctrl_stb_n, cs_main_n, cs_hi, cs_lo_n, adv_n;
  logic          wr_all_n, byte_wr_n;
  logic [NB-1:0] lane_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          out_en_n;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [DW-1:0] exp_mem [DP];

  sbsram_core #(.DATA_W(DW), .BYTE_W(BW), .DEPTH(DP)) dut (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .lin_order(lin_order),
    .snooze(snooze), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
    .cs_main_n(cs_main_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .adv_n(adv_n),
    .wr_all_n(wr_all_n), .byte_wr_n(byte_wr_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .wdata(wdata), .out_en_n(out_en_n),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_inputs();
    proc_stb_n = 1'b1; ctrl_stb_n = 1'b1;
    cs_main_n  = 1'b0; cs_hi = 1'b1; cs_lo_n = 1'b0;
    adv_n      = 1'b1; wr_all_n = 1'b1; byte_wr_n = 1'b1;
    lane_wr_n  = '1;   out_en_n = 1'b0; snooze = 1'b0;
  endtask

  task automatic wr_begin(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ctrl_stb_n = 1'b0; addr = a; wdata = d; wr_all_n = 1'b0;
    step();
    exp_mem[a] = d;
    chk("R9 write edge drives nothing", {31'd0, rdata_oe}, 32'd0);
    idle_inputs();
  endtask

  task automatic rd_begin(input logic [AW-1:0] a);
    proc_stb_n = 1'b0; addr = a;
    step();
    idle_inputs();
  endtask

  task automatic desel();
    proc_stb_n = 1'b0; cs_hi = 1'b0;
    step();
    idle_inputs();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle_inputs(); flow_mode = 1'b1; lin_order = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) step();
    chk("R12 no drive in reset", {31'd0, rdata_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R12 no drive after reset", {31'd0, rdata_oe}, 32'd0);
  endtask

  task automatic t_basic();
    wr_begin(4'd5, 18'h2A5A5);
    // processor strobe with writes asserted must still read
    proc_stb_n = 1'b0; ctrl_stb_n = 1'b0; wr_all_n = 1'b0; addr = 4'd5; wdata = 18'h00111;
    step();
    idle_inputs();
    chk("R1 read starts", {31'd0, rdata_oe}, 32'd1);
    chk("R8 flow data same cycle", rdata, exp_mem[5]);
    rd_begin(4'd5);
    chk("R1 no write on proc edge", rdata, exp_mem[5]);
    // controller strobe without write enables is a read
    ctrl_stb_n = 1'b0; addr = 4'd5;
    step();
    idle_inputs();
    chk("R2 ctrl read", rdata, exp_mem[5]);
  endtask

  task automatic t_lanes();
    wr_begin(4'd3, 18'h3FFFF);
    ctrl_stb_n = 1'b0; addr = 4'd3; wdata = 18'h00000;
    byte_wr_n = 1'b0; lane_wr_n = 2'b10;
    step();
    idle_inputs();
    exp_mem[3] = 18'h3FE00;
    chk("R4 lane write drives nothing", {31'd0, rdata_oe}, 32'd0);
    ctrl_stb_n = 1'b0; addr = 4'd3; lane_wr_n = 2'b00; wdata = 18'h0;
    step();
    idle_inputs();
    chk("R4 lanes without enable read", {31'd0, rdata_oe}, 32'd1);
    chk("R4 only lane 0 written", rdata, exp_mem[3]);
    ctrl_stb_n = 1'b0; addr = 4'd3; wr_all_n = 1'b0; byte_wr_n = 1'b1; lane_wr_n = 2'b11;
    wdata = 18'h15555;
    step();
    idle_inputs();
    exp_mem[3] = 18'h15555;
    rd_begin(4'd3);
    chk("R4 global writes all lanes", rdata, exp_mem[3]);
  endtask

  task automatic t_orders();
    for (int i = 8; i < 12; i++) wr_begin(AW'(i), DW'(18'h100 + i * 7));
    lin_order = 1'b0;
    rd_begin(4'd9);
    chk("R6 xor beat0", rdata, exp_mem[9]);
    adv_n = 1'b0; step(); chk("R6 xor beat1", rdata, exp_mem[8]);
    step(); chk("R6 xor beat2", rdata, exp_mem[11]);
    step(); chk("R6 xor beat3", rdata, exp_mem[10]);
    adv_n = 1'b1; step(); chk("R5 hold keeps beat", rdata, exp_mem[10]);
    lin_order = 1'b1;
    rd_begin(4'd9);
    adv_n = 1'b0; step(); chk("R6 linear beat1", rdata, exp_mem[10]);
    step(); chk("R6 linear beat2", rdata, exp_mem[11]);
    step(); chk("R6 linear beat3", rdata, exp_mem[8]);
    idle_inputs();
    lin_order = 1'b0;
  endtask

  task automatic t_write_burst();
    wr_begin(4'd12, 18'h01234);
    wr_all_n = 1'b0; adv_n = 1'b0; wdata = 18'h05678;
    step();
    chk("R9 burst write drives nothing", {31'd0, rdata_oe}, 32'd0);
    adv_n = 1'b1; wdata = 18'h09ABC;
    step();
    exp_mem[13] = 18'h09ABC;
    wr_all_n = 1'b1; byte_wr_n = 1'b0; lane_wr_n = 2'b01; adv_n = 1'b0; wdata = 18'h3FFFF;
    step();
    exp_mem[14] = {9'h1FF, exp_mem[14][8:0]};
    idle_inputs();
    rd_begin(4'd12); chk("R5 write burst beat0", rdata, exp_mem[12]);
    rd_begin(4'd13); chk("R5 write hold overwrote", rdata, exp_mem[13]);
    rd_begin(4'd14); chk("R5 lane write in burst", rdata, exp_mem[14]);
  endtask

  task automatic t_oe();
    rd_begin(4'd5);
    out_en_n = 1'b1; #1;
    chk("R9 oe off async", {31'd0, rdata_oe}, 32'd0);
    out_en_n = 1'b0; #1;
    chk("R9 oe on async", {31'd0, rdata_oe}, 32'd1);
  endtask

  task automatic t_gating();
    rd_begin(4'd8);
    cs_main_n = 1'b1; proc_stb_n = 1'b0; adv_n = 1'b0;
    step();
    idle_inputs();
    chk("R3 blocked strobe continues", {31'd0, rdata_oe}, 32'd1);
    chk("R3 blocked strobe steps", rdata, exp_mem[9]);
    desel();
    chk("R3 deselect turns off", {31'd0, rdata_oe}, 32'd0);
    step();
    cs_main_n = 1'b1; proc_stb_n = 1'b0; addr = 4'd5;
    step();
    idle_inputs();
    chk("R3 blocked strobe starts nothing", {31'd0, rdata_oe}, 32'd0);
    cs_main_n = 1'b1; ctrl_stb_n = 1'b0; wr_all_n = 1'b0; addr = 4'd5; wdata = 18'h0;
    step();
    idle_inputs();
    cs_lo_n = 1'b1; ctrl_stb_n = 1'b0; wr_all_n = 1'b0; addr = 4'd5; wdata = 18'h0;
    step();
    idle_inputs();
    rd_begin(4'd5);
    chk("R3 deselected ctrl no write", rdata, exp_mem[5]);
  endtask

  task automatic t_pipe();
    desel();
    step();
    flow_mode = 1'b0;
    step();
    rd_begin(4'd12);
    chk("R7 not yet driven", {31'd0, rdata_oe}, 32'd0);
    step();
    chk("R7 driven next cycle", {31'd0, rdata_oe}, 32'd1);
    chk("R7 pipelined data", rdata, exp_mem[12]);
    desel();
    chk("R10 drive one more cycle", {31'd0, rdata_oe}, 32'd1);
    chk("R10 pending data", rdata, exp_mem[12]);
    step();
    chk("R10 then off", {31'd0, rdata_oe}, 32'd0);
    flow_mode = 1'b1;
    step();
  endtask

  task automatic t_snooze();
    rd_begin(4'd5);
    snooze = 1'b1; #1;
    chk("R11 off in snooze", {31'd0, rdata_oe}, 32'd0);
    ctrl_stb_n = 1'b0; wr_all_n = 1'b0; addr = 4'd5; wdata = 18'h00777;
    step();
    step();
    chk("R11 still off", {31'd0, rdata_oe}, 32'd0);
    idle_inputs(); #1;
    chk("R11 resumes", {31'd0, rdata_oe}, 32'd1);
    chk("R11 data kept", rdata, exp_mem[5]);
    rd_begin(4'd5);
    chk("R11 no write in snooze", rdata, exp_mem[5]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_lanes();
    t_orders();
    t_write_burst();
    t_oe();
    t_gating();
    t_pipe();
    t_snooze();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule